// File: doc/BRIEF.md
# Thermally Throttled Round-Robin Arbiter

This block is the output-port arbiter of a mesh router. It looks at one input port per poll, visiting ports in a fixed circular order. When the polled port is requesting, that port receives a one-hot grant. Nothing is granted when the polled port is idle, and the poll moves on in either case.

To reduce switching in the crossbar and the link drivers when the tile runs hot, the arbiter can insert idle cycles after each poll. The number of idle cycles is the throttle level. The level is the number of half-kelvin steps by which the local temperature code exceeds a programmed trigger code, limited to a programmed ceiling.

Both outputs are registered. The grant and stall outputs describe the decision made at the previous clock edge.

Top module: `thermal_rr_arbiter`

## Requirements
- R1: While `rst` is high, both `grant` and `stall` read zero one edge later. The first poll after reset visits port 0.
- R2: At throttle level 0, one port is polled on every clock edge, in ascending index order, wrapping from `N_PORTS-1` back to 0. `grant` shows the one-hot code of the polled port, bit i meaning port i, after that edge when that port's `req` bit was high at the edge.
- R3: The poll pointer advances after every poll, whether or not the poll produced a grant.
- R4: Temperature codes count half-kelvin steps above 300 K, so code 64 is 332 K, which is the usual trigger. The throttle level is `temp_code - trig_code` when `temp_code` is above `trig_code`, and 0 otherwise.
- R5: The throttle level never exceeds `max_level`.
- R6: A `temp_code` above 140, which is 370 K, is treated as 140.
- R7: After a poll made at level L, exactly L cycles follow with `stall` high and `grant` zero. The next poll comes on the edge after those cycles.
- R8: The level is captured at the poll that starts a stall period. Later changes to `temp_code` do not lengthen or shorten that period.
- R9: `grant` has at most one bit set, and only for a port whose `req` bit was high at the deciding edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_PORTS | Request bit per input port |
| temp_code | input | TEMP_W | Local temperature code, 0.5 K per step above 300 K |
| trig_code | input | TEMP_W | Code at which throttling begins |
| max_level | input | LVL_W | Ceiling on the throttle level |
| grant | output | N_PORTS | Registered one-hot grant |
| stall | output | 1 | Registered flag, high during a throttle idle cycle |

## Verification
The stall-length checker assumes `max_level` changes only while `rst` is high. It compares each run of stall cycles with the ceiling in force at that moment, so the bench programs the ceiling only inside its reset task. The request-matching property assumes `req` is settled at every clock edge. The bench therefore drives all inputs on the falling edge. Temperature is the only input changed in the middle of a scenario, and that change is what exercises level capture.

// File: rtl/tra_pkg.sv
package tra_pkg;
  // Highest meaningful temperature code: 370 K at 0.5 K per step from 300 K.
  localparam int TEMP_CODE_CEIL = 140;
  // Customary trigger: 332 K.
  localparam int TRIG_CODE_TYPICAL = 64;
endpackage

// File: rtl/tra_level.sv
module tra_level #(
  parameter int TEMP_W   = 8,
  parameter int LVL_W    = 4,
  parameter int TEMP_TOP = tra_pkg::TEMP_CODE_CEIL
) (
  input  logic [TEMP_W-1:0] temp_code,
  input  logic [TEMP_W-1:0] trig_code,
  input  logic [LVL_W-1:0]  max_level,
  output logic [LVL_W-1:0]  level
);
  localparam logic [TEMP_W-1:0] TOP = TEMP_W'(TEMP_TOP);

  logic [TEMP_W-1:0] temp_sat;
  logic [TEMP_W-1:0] excess;
  logic [TEMP_W-1:0] ceil_ext;

  always_comb begin
    temp_sat = (temp_code > TOP) ? TOP : temp_code;
    excess   = (temp_sat > trig_code) ? (temp_sat - trig_code) : '0;
    ceil_ext = TEMP_W'(max_level);
    level    = (excess > ceil_ext) ? max_level : excess[LVL_W-1:0];
  end
endmodule

// File: rtl/tra_poll.sv
module tra_poll #(
  parameter int N_PORTS = 5,
  parameter int LVL_W   = 4,
  localparam int PTR_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] level,
  output logic             poll_now,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(N_PORTS - 1);

  logic [LVL_W-1:0] wait_cnt;

  assign poll_now = (wait_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= '0;
      wait_cnt <= '0;
    end else if (poll_now) begin
      ptr      <= (ptr == LAST) ? '0 : ptr + 1'b1;
      wait_cnt <= level;
    end else begin
      wait_cnt <= wait_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/thermal_rr_arbiter.sv
module thermal_rr_arbiter #(
  parameter int N_PORTS = 5,
  parameter int TEMP_W  = 8,
  parameter int LVL_W   = 4,
  localparam int PTR_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_PORTS-1:0] req,
  input  logic [TEMP_W-1:0]  temp_code,
  input  logic [TEMP_W-1:0]  trig_code,
  input  logic [LVL_W-1:0]   max_level,
  output logic [N_PORTS-1:0] grant,
  output logic               stall
);
  logic [LVL_W-1:0]   level;
  logic               poll_now;
  logic [PTR_W-1:0]   ptr;
  logic [N_PORTS-1:0] pick;

  tra_level #(.TEMP_W(TEMP_W), .LVL_W(LVL_W)) u_level (
    .temp_code (temp_code),
    .trig_code (trig_code),
    .max_level (max_level),
    .level     (level)
  );

  tra_poll #(.N_PORTS(N_PORTS), .LVL_W(LVL_W)) u_poll (
    .clk      (clk),
    .rst      (rst),
    .level    (level),
    .poll_now (poll_now),
    .ptr      (ptr)
  );

  for (genvar g = 0; g < N_PORTS; g++) begin : g_pick
    assign pick[g] = poll_now && req[g] && (ptr == PTR_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant <= '0;
      stall <= 1'b0;
    end else begin
      grant <= pick;
      stall <= !poll_now;
    end
  end
endmodule

// File: rtl/thermal_rr_arbiter_chk.sv
module thermal_rr_arbiter_chk #(
  parameter int N_PORTS = 5,
  parameter int LVL_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [N_PORTS-1:0] req,
  input logic [LVL_W-1:0]   max_level,
  input logic [N_PORTS-1:0] grant,
  input logic               stall
);
  // Consecutive stall samples seen before the current one.
  logic [LVL_W:0] run;

  always_ff @(posedge clk) begin
    if (rst)        run <= '0;
    else if (stall) run <= (run == '1) ? run : run + 1'b1;
    else            run <= '0;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (grant == '0 && !stall));

  a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  a_r9_only_requesters: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |-> ((grant & ~$past(req)) == '0));

  a_r7_quiet_in_stall: assert property (@(posedge clk) disable iff (rst)
    stall |-> (grant == '0));

  a_r5_run_within_ceiling: assert property (@(posedge clk) disable iff (rst)
    stall |-> (run < {1'b0, max_level}));
endmodule

bind thermal_rr_arbiter thermal_rr_arbiter_chk #(.N_PORTS(N_PORTS), .LVL_W(LVL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .max_level (max_level),
  .grant     (grant),
  .stall     (stall)
);

// File: tb/thermal_rr_arbiter_test.sv
module thermal_rr_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 5;
  localparam int TW = 8;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req = '0;
  logic [TW-1:0] temp_code = '0;
  logic [TW-1:0] trig_code = 8'd64;
  logic [LW-1:0] max_level = '0;
  logic [N-1:0]  grant;
  logic          stall;

  int checks = 0;
  int errors = 0;

  thermal_rr_arbiter #(.N_PORTS(N), .TEMP_W(TW), .LVL_W(LW)) uut (
    .clk(clk), .rst(rst), .req(req), .temp_code(temp_code),
    .trig_code(trig_code), .max_level(max_level),
    .grant(grant), .stall(stall)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(string tag, logic [N-1:0] eg, logic es);
    checks++;
    if (grant !== eg || stall !== es) begin
      errors++;
      $display("FAIL %s: actual grant=%b stall=%b expected grant=%b stall=%b",
               tag, grant, stall, eg, es);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // R1: reset clears the outputs; config is loaded only here.
  task automatic do_reset(logic [TW-1:0] trig, logic [LW-1:0] maxl,
                          logic [TW-1:0] temp, logic [N-1:0] rq);
    @(negedge clk);
    rst = 1'b1;
    trig_code = trig; max_level = maxl; temp_code = temp; req = rq;
    step();
    chk("R1 reset outputs", '0, 1'b0);
    step();
    rst = 1'b0;
  endtask

  // One poll every 'period' cycles, pointer walking 0..N-1 from port 0.
  task automatic run_periodic(string tag, int period, int ncyc);
    for (int c = 0; c < ncyc; c++) begin
      logic [N-1:0] eg;
      int port;
      step();
      eg = '0;
      port = (c / period) % N;
      if (c % period == 0 && req[port]) eg[port] = 1'b1;
      chk(tag, eg, (c % period) != 0);
    end
  endtask

  task automatic t_reset();
    do_reset(8'd64, 4'd15, 8'd67, 5'b11111);
    run_periodic("R1 first poll at port 0", 4, 2);
    do_reset(8'd64, 4'd15, 8'd67, 5'b11111);
  endtask

  task automatic t_no_throttle();
    do_reset(8'd64, 4'd15, 8'd60, 5'b11111);
    run_periodic("R2 order at level 0", 1, 12);
  endtask

  task automatic t_sparse();
    do_reset(8'd64, 4'd15, 8'd64, 5'b00100);
    run_periodic("R3 advance without grant, R4 temp equals trigger", 1, 11);
  endtask

  task automatic t_level();
    do_reset(8'd64, 4'd15, 8'd67, 5'b11111);
    run_periodic("R4 R7 level 3 stalls", 4, 14);
  endtask

  task automatic t_clamp();
    do_reset(8'd64, 4'd2, 8'd74, 5'b11111);
    run_periodic("R5 ceiling 2", 3, 12);
  endtask

  task automatic t_saturate();
    do_reset(8'd138, 4'd15, 8'd200, 5'b11111);
    run_periodic("R6 code above 140 saturates", 3, 12);
  endtask

  task automatic t_sparse_throttle();
    do_reset(8'd64, 4'd15, 8'd65, 5'b00010);
    run_periodic("R3 R9 single requester level 1", 2, 12);
    do_reset(8'd64, 4'd15, 8'd66, 5'b00000);
    run_periodic("R9 no requester no grant", 3, 6);
  endtask

  task automatic t_capture();
    do_reset(8'd64, 4'd15, 8'd67, 5'b11111);
    step();
    chk("R8 poll port 0", 5'b00001, 1'b0);
    temp_code = 8'd65;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R8 captured level 3 holds", '0, 1'b1);
    end
    step();
    chk("R8 next poll port 1", 5'b00010, 1'b0);
    step();
    chk("R8 new level 1 stall", '0, 1'b1);
    step();
    chk("R8 poll port 2", 5'b00100, 1'b0);
  endtask

  initial begin
    t_reset();
    t_no_throttle();
    t_sparse();
    t_level();
    t_clamp();
    t_saturate();
    t_sparse_throttle();
    t_capture();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule